// File: doc/BRIEF.md
# ECC Read-Modify-Write Write Path

This block sits between a host command port and a memory controller command port. It protects every stored word with a single-error-correcting, double-error-detecting code. Each data word of `DATA_W` bits is stored with check bits, so the default 64-bit word becomes 72 bits. A write that enables every byte is encoded and forwarded in the next cycle. Host reads are forwarded. Their returned words are decoded and corrected, and they reach the host one cycle after the memory controller hands them back.

A write with any byte enable cleared cannot be stored as-is, because the check bits cover the whole word. The block therefore drops its ready signal and issues its own read of that address. It decodes and corrects the returned word, overlays the enabled bytes of the pending write, and re-encodes the result. It then sends the result as a write to the same address and accepts host commands again. An uncorrectable word found during that read cancels the write-back. Single-bit and double-bit events are counted in saturating counters. Uncorrectable events latch into a two-bit status register that drives a level interrupt until a clear pulse.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: A host write with all byte enables set is sent as a memory write to the same address in the cycle after acceptance. Stored word bit 0 is the overall parity bit, so the XOR over all `CW` bits of any word the block writes is zero. A later host read returns the written data.
- R2: A host read produces a memory read command to the same address in the cycle after acceptance. Its data reaches `host_rvalid`/`host_rdata` exactly one cycle after the matching `mem_rvalid`.
- R3: For a write with at least one byte enable cleared, the block issues a memory read of that address in the cycle after acceptance. `host_ready` stays low from that cycle until the write-back command is issued.
- R4: The write-back data is the stored word with byte i (bits 8i+7..8i) replaced by new data wherever `host_be[i]` is 1, including the case where no byte is enabled. It goes to the same address, and `host_ready` is high again in the same cycle the write-back command is presented.
- R5: A single-bit error in the word read for a partial write is corrected before the merge, `sbe_count` increments by one, and the write-back stores a clean word.
- R6: A double-bit error in the word read for a partial write suppresses the write-back, increments `dbe_count`, and sets `irq_status[1]`.
- R7: A host read whose word has a single-bit error returns corrected data with `host_rerr` low and increments `sbe_count`.
- R8: A host read whose word has a double-bit error returns `host_rerr` high, increments `dbe_count` and sets `irq_status[0]`.
- R9: Both counters saturate at all ones (`2**CNT_W-1`).
- R10: A `clr` pulse zeroes both counters and both status bits in the next cycle.
- R11: `irq` is high whenever any `irq_status` bit is set, and stays high until a clear.
- R12: Responses to host reads issued before a partial write still go to the host in order. The partial write uses only its own read response.
- R13: After reset, `host_ready` is high, no command or response is valid, and both counters, the status and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears error counters and status |
| host_valid | input | 1 | Host command valid |
| host_ready | output | 1 | Host command accepted when high; low during read-modify-write |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | DATA_W/8 | Byte enables, bit i covers data bits 8i+7..8i |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | DATA_W | Corrected read data |
| host_rerr | output | 1 | Read data uncorrectable |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_write | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | ADDR_W | Memory word address |
| mem_cmd_wdata | output | CW | Encoded write word |
| mem_rvalid | input | 1 | Memory read data valid, in command order |
| mem_rdata | input | CW | Encoded read word |
| sbe_count | output | CNT_W | Corrected-error count |
| dbe_count | output | CNT_W | Uncorrectable-error count |
| irq_status | output | 2 | Bit 0 host read uncorrectable, bit 1 partial write aborted |
| irq | output | 1 | Interrupt, high while status is non-zero |

## Verification
Commands are due one cycle after the accepting edge, and the bench samples them at the following falling edge. Read data is due `MEM_LAT+2` edges after acceptance: one edge for the command register, the memory model's latency, and one edge for the decode register. The bench counts falling edges from acceptance and checks that exact count. A partial write holds `host_ready` low for `MEM_LAT+2` sampled cycles. The bench checks that the write-back command is present at the first falling edge where ready is high again. Counters and status update on the edge that captures the read response, so they are checked only after that response has been observed.

// File: rtl/ecc_rmw_pkg.sv
// Package: shared FSM state type and constant helpers for the SECDED code.
// Assumes Hamming positions 1..CW-1 with check bits at powers of two.
package ecc_rmw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_MERGE   = 2'd2
    } rmw_state_t;

    // Number of Hamming check bits needed for a data width (excludes overall parity).
    function automatic int hamming_checks(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // True when v is a power of two (a check-bit position).
    function automatic logic is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    // True when codeword position pos is covered by check bit bitn.
    function automatic logic covers(input int pos, input int bitn);
        return ((pos >> bitn) & 1) != 0;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
// Module: SECDED encoder. Places data at non-power-of-two positions,
// fills Hamming check bits at power-of-two positions, overall parity at bit 0.
// Assumes: purely combinational; DATA_W >= 4.
module ecc_secded_enc
    import ecc_rmw_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int P     = hamming_checks(DATA_W),
    localparam int CW    = DATA_W + P + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW-1:0]     code_o
);

    logic [CW-1:1] placed;
    logic [CW-1:1] hword;
    logic [P-1:0]  par;

    // Scatter data bits onto the data positions of the codeword.
    always_comb begin
        int j;
        j = 0;
        placed = '0;
        for (int pos = 1; pos < CW; pos++) begin
            if (!is_pow2(pos)) begin
                placed[pos] = data_i[j];
                j++;
            end
        end
    end

    // Compute each check bit over the positions it covers.
    always_comb begin
        par = '0;
        for (int g = 0; g < P; g++) begin
            for (int pos = 1; pos < CW; pos++) begin
                if (covers(pos, g)) par[g] = par[g] ^ placed[pos];
            end
        end
    end

    // Insert check bits at their power-of-two positions.
    always_comb begin
        hword = placed;
        for (int g = 0; g < P; g++) begin
            hword[1 << g] = par[g];
        end
    end

    assign code_o = {hword, ^hword};

endmodule

// File: rtl/ecc_secded_dec.sv
// Module: SECDED decoder. Computes the syndrome and overall parity, flips one
// bit when a single error is located, and extracts the data bits.
// Assumes: same layout as ecc_secded_enc; purely combinational.
module ecc_secded_dec
    import ecc_rmw_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int P     = hamming_checks(DATA_W),
    localparam int CW    = DATA_W + P + 1
) (
    input  logic [CW-1:0]     code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sbe_o,
    output logic              dbe_o
);

    logic [P-1:0]  syn;
    logic          ovr;
    logic          syn_ok;
    logic [CW-1:1] fixed;

    // Syndrome: recompute each check over the received word.
    always_comb begin
        syn = '0;
        for (int g = 0; g < P; g++) begin
            for (int pos = 1; pos < CW; pos++) begin
                if (covers(pos, g)) syn[g] = syn[g] ^ code_i[pos];
            end
        end
    end

    assign ovr    = ^code_i;
    assign syn_ok = int'(syn) < CW;

    // Correct the located bit when overall parity shows an odd error count.
    always_comb begin
        fixed = code_i[CW-1:1];
        for (int pos = 1; pos < CW; pos++) begin
            if (ovr && (int'(syn) == pos)) fixed[pos] = ~fixed[pos];
        end
    end

    // Gather data bits back from the data positions.
    always_comb begin
        int j;
        j = 0;
        data_o = '0;
        for (int pos = 1; pos < CW; pos++) begin
            if (!is_pow2(pos)) begin
                data_o[j] = fixed[pos];
                j++;
            end
        end
    end

    assign sbe_o = ovr && syn_ok;
    assign dbe_o = (!ovr && (syn != '0)) || (ovr && !syn_ok);

endmodule

// File: rtl/ecc_byte_merge.sv
// Module: byte-lane merge. Takes new bytes where enabled, old bytes elsewhere.
// Assumes: DATA_W is a multiple of 8.
module ecc_byte_merge #(
    parameter int DATA_W  = 64,
    localparam int BYTES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [BYTES-1:0]  be_i,
    output logic [DATA_W-1:0] out_o
);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign out_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
    end

endmodule

// File: rtl/ecc_err_log.sv
// Module: error logger. Two saturating counters and a sticky two-bit
// status register with level interrupt. Clear has priority over new events.
// Assumes: events are single-cycle qualified pulses.
module ecc_err_log #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sbe_ev,
    input  logic             dbe_ev,
    input  logic             rd_fatal_ev,
    input  logic             rmw_abort_ev,
    output logic [CNT_W-1:0] sbe_count,
    output logic [CNT_W-1:0] dbe_count,
    output logic [1:0]       status,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0] ev;
    assign ev = {dbe_ev, sbe_ev};

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        logic [CNT_W-1:0] q;
        // Saturating event counter.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)             q <= '0;
            else if (ev[g] && q != CNT_MAX) q <= q + 1'b1;
        end
    end

    assign sbe_count = g_cnt[0].q;
    assign dbe_count = g_cnt[1].q;

    // Sticky status bits for uncorrectable events.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) status <= '0;
        else               status <= status | {rmw_abort_ev, rd_fatal_ev};
    end

    assign irq = |status;

endmodule

// File: rtl/ecc_rmw_ctrl.sv
// Module: top of the ECC write path. Encodes full writes, decodes reads, and
// runs read-modify-write for byte-masked writes with host stall.
// Assumes: the memory controller accepts every command and returns read data
// in command order; at most MAX_RD reads are outstanding.
module ecc_rmw_ctrl
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 64,
    parameter int CNT_W   = 16,
    parameter int MAX_RD  = 8,
    localparam int BYTES  = DATA_W / 8,
    localparam int CW     = DATA_W + hamming_checks(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [BYTES-1:0]  host_be,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rerr,
    output logic              mem_cmd_valid,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [CW-1:0]     mem_cmd_wdata,
    input  logic              mem_rvalid,
    input  logic [CW-1:0]     mem_rdata,
    output logic [CNT_W-1:0]  sbe_count,
    output logic [CNT_W-1:0]  dbe_count,
    output logic [1:0]        irq_status,
    output logic              irq
);

    localparam int OUT_W = $clog2(MAX_RD + 1);

    rmw_state_t        state_q;
    logic [ADDR_W-1:0] rmw_addr_q;
    logic [DATA_W-1:0] rmw_data_q;
    logic [BYTES-1:0]  rmw_be_q;
    logic              rmw_abort_q;
    logic [DATA_W-1:0] mrg_d, mrg_q;
    logic [OUT_W-1:0]  out_cnt_q, skip_q;

    logic              accept, acc_full, acc_partial, rd_issue, rsp_own;
    logic [DATA_W-1:0] dec_data, enc_in;
    logic              dec_sbe, dec_dbe;
    logic [CW-1:0]     enc_code;

    assign host_ready  = (state_q == ST_IDLE);
    assign accept      = host_valid && host_ready;
    assign acc_full    = accept && host_write && (&host_be);
    assign acc_partial = accept && host_write && !(&host_be);
    assign rd_issue    = accept && !(host_write && (&host_be));
    assign rsp_own     = (state_q == ST_RD_WAIT) && (skip_q == '0) && mem_rvalid;

    ecc_secded_dec #(.DATA_W(DATA_W)) u_dec (
        .code_i (mem_rdata),
        .data_o (dec_data),
        .sbe_o  (dec_sbe),
        .dbe_o  (dec_dbe)
    );

    ecc_byte_merge #(.DATA_W(DATA_W)) u_merge (
        .old_i (dec_data),
        .new_i (rmw_data_q),
        .be_i  (rmw_be_q),
        .out_o (mrg_d)
    );

    assign enc_in = (state_q == ST_MERGE) ? mrg_q : host_wdata;

    ecc_secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_in),
        .code_o (enc_code)
    );

    // Track reads in flight at the memory controller.
    always_ff @(posedge clk) begin
        if (!rst_n) out_cnt_q <= '0;
        else        out_cnt_q <= out_cnt_q + OUT_W'(rd_issue) - OUT_W'(mem_rvalid);
    end

    // Read-modify-write sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rmw_addr_q  <= '0;
            rmw_data_q  <= '0;
            rmw_be_q    <= '0;
            rmw_abort_q <= 1'b0;
            mrg_q       <= '0;
            skip_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (acc_partial) begin
                        state_q    <= ST_RD_WAIT;
                        rmw_addr_q <= host_addr;
                        rmw_data_q <= host_wdata;
                        rmw_be_q   <= host_be;
                        skip_q     <= out_cnt_q - OUT_W'(mem_rvalid);
                    end
                end
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        if (skip_q == '0) begin
                            state_q     <= ST_MERGE;
                            mrg_q       <= mrg_d;
                            rmw_abort_q <= dec_dbe;
                        end else begin
                            skip_q <= skip_q - 1'b1;
                        end
                    end
                end
                ST_MERGE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory command register: host command or write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cmd_valid <= 1'b0;
            mem_cmd_write <= 1'b0;
            mem_cmd_addr  <= '0;
            mem_cmd_wdata <= '0;
        end else begin
            mem_cmd_valid <= 1'b0;
            if (state_q == ST_MERGE) begin
                mem_cmd_valid <= !rmw_abort_q;
                mem_cmd_write <= 1'b1;
                mem_cmd_addr  <= rmw_addr_q;
                mem_cmd_wdata <= enc_code;
            end else if (accept) begin
                mem_cmd_valid <= 1'b1;
                mem_cmd_write <= acc_full;
                mem_cmd_addr  <= host_addr;
                mem_cmd_wdata <= enc_code;
            end
        end
    end

    // Host read response register (one cycle of decode latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
            host_rerr   <= 1'b0;
        end else begin
            host_rvalid <= mem_rvalid && !rsp_own;
            if (mem_rvalid) begin
                host_rdata <= dec_data;
                host_rerr  <= dec_dbe;
            end
        end
    end

    ecc_err_log #(.CNT_W(CNT_W)) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .sbe_ev       (mem_rvalid && dec_sbe),
        .dbe_ev       (mem_rvalid && dec_dbe),
        .rd_fatal_ev  (mem_rvalid && dec_dbe && !rsp_own),
        .rmw_abort_ev (rsp_own && dec_dbe),
        .sbe_count    (sbe_count),
        .dbe_count    (dbe_count),
        .status       (irq_status),
        .irq          (irq)
    );

endmodule

// File: rtl/ecc_rmw_ctrl_checker.sv
// Module: protocol checker bound to ecc_rmw_ctrl; observes ports only.
// Assumes: synchronous active-low reset held from time zero.
module ecc_rmw_ctrl_checker #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int BYTES  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              host_valid,
    input logic              host_ready,
    input logic              host_write,
    input logic [ADDR_W-1:0] host_addr,
    input logic [BYTES-1:0]  host_be,
    input logic              host_rvalid,
    input logic              mem_cmd_valid,
    input logic              mem_cmd_write,
    input logic [ADDR_W-1:0] mem_cmd_addr,
    input logic              mem_rvalid,
    input logic [CNT_W-1:0]  sbe_count,
    input logic [CNT_W-1:0]  dbe_count,
    input logic [1:0]        irq_status,
    input logic              irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_full_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_ready && host_write && (&host_be)
        |=> mem_cmd_valid && mem_cmd_write && mem_cmd_addr == $past(host_addr));

    p_read_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_ready && !host_write
        |=> mem_cmd_valid && !mem_cmd_write && mem_cmd_addr == $past(host_addr));

    p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(mem_rvalid));

    p_partial_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_ready && host_write && !(&host_be)
        |=> !host_ready && mem_cmd_valid && !mem_cmd_write
            && mem_cmd_addr == $past(host_addr));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && mem_cmd_write && $past(!host_ready) |-> host_ready);

    p_sbe_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && sbe_count == CNT_MAX |=> sbe_count == CNT_MAX);

    p_dbe_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && dbe_count == CNT_MAX |=> dbe_count == CNT_MAX);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sbe_count == '0 && dbe_count == '0 && irq_status == 2'b00);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr |=> irq);

endmodule

bind ecc_rmw_ctrl ecc_rmw_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BYTES  (BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .host_valid    (host_valid),
    .host_ready    (host_ready),
    .host_write    (host_write),
    .host_addr     (host_addr),
    .host_be       (host_be),
    .host_rvalid   (host_rvalid),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_write (mem_cmd_write),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_rvalid    (mem_rvalid),
    .sbe_count     (sbe_count),
    .dbe_count     (dbe_count),
    .irq_status    (irq_status),
    .irq           (irq)
);

// File: tb/tb_ecc_rmw_ctrl.sv
module tb_ecc_rmw_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW      = 4;
    localparam int DW      = 64;
    localparam int BY      = DW / 8;
    localparam int CNT_W   = 3;
    localparam int CW      = DW + ecc_rmw_pkg::hamming_checks(DW) + 1;
    localparam int MEM_LAT = 2;
    localparam int NVEC    = 8;

    // {addr, data, byte enables}
    localparam logic [AW+DW+BY-1:0] VECS [NVEC] = '{
        {4'd1, 64'h0123_4567_89AB_CDEF, 8'hFF},
        {4'd2, 64'hFEDC_BA98_7654_3210, 8'hFF},
        {4'd3, 64'h0000_0000_0000_0000, 8'hFF},
        {4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF},
        {4'd1, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F},
        {4'd2, 64'h5555_5555_5555_5555, 8'h80},
        {4'd3, 64'h1122_3344_5566_7788, 8'h00},
        {4'd4, 64'h0000_0000_0000_0000, 8'h5A}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          host_valid = 1'b0;
    logic          host_ready;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [BY-1:0] host_be = '0;
    logic          host_rvalid;
    logic [DW-1:0] host_rdata;
    logic          host_rerr;
    logic          mem_cmd_valid;
    logic          mem_cmd_write;
    logic [AW-1:0] mem_cmd_addr;
    logic [CW-1:0] mem_cmd_wdata;
    logic          mem_rvalid;
    logic [CW-1:0] mem_rdata;
    logic [CNT_W-1:0] sbe_count, dbe_count;
    logic [1:0]    irq_status;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;

    logic [CW-1:0] mem [16];
    logic [CW-1:0] rpipe [MEM_LAT];
    logic          vpipe [MEM_LAT];
    logic [DW-1:0] shadow [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_rmw_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CNT_W), .MAX_RD(8)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_rerr(host_rerr),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .sbe_count(sbe_count), .dbe_count(dbe_count),
        .irq_status(irq_status), .irq(irq)
    );

    // Memory model: fixed read latency, in-order responses.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_LAT; i++) vpipe[i] <= 1'b0;
        end else begin
            if (mem_cmd_valid && mem_cmd_write) begin
                mem[mem_cmd_addr] <= mem_cmd_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            vpipe[0] <= mem_cmd_valid && !mem_cmd_write;
            rpipe[0] <= mem[mem_cmd_addr];
            for (int i = 1; i < MEM_LAT; i++) begin
                vpipe[i] <= vpipe[i-1];
                rpipe[i] <= rpipe[i-1];
            end
        end
    end
    assign mem_rvalid = vpipe[MEM_LAT-1];
    assign mem_rdata  = rpipe[MEM_LAT-1];

    function automatic logic [DW-1:0] merge_exp(input logic [DW-1:0] o,
                                                input logic [DW-1:0] n,
                                                input logic [BY-1:0] be);
        logic [DW-1:0] r;
        r = o;
        for (int b = 0; b < BY; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [BY-1:0] be, input logic abort_exp,
                            input string req);
        int n;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d; host_be = be;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
        if (&be) begin
            check(mem_cmd_valid && mem_cmd_write && mem_cmd_addr == a, "R1", "full write cmd",
                  {mem_cmd_valid, mem_cmd_write, mem_cmd_addr}, {2'b11, a});
            check(^mem_cmd_wdata == 1'b0, "R1", "overall parity", ^mem_cmd_wdata, 0);
            shadow[a] = d;
        end else begin
            check(mem_cmd_valid && !mem_cmd_write && mem_cmd_addr == a, "R3", "internal read cmd",
                  {mem_cmd_valid, mem_cmd_write, mem_cmd_addr}, {2'b10, a});
            n = 0;
            while (!host_ready && n < 100) begin
                n++;
                @(negedge clk);
            end
            check(n == MEM_LAT + 2, "R3", "stall cycles", n, MEM_LAT + 2);
            if (abort_exp) begin
                check(!mem_cmd_valid, req, "write-back suppressed", mem_cmd_valid, 0);
            end else begin
                check(mem_cmd_valid && mem_cmd_write && mem_cmd_addr == a, req, "write-back cmd",
                      {mem_cmd_valid, mem_cmd_write, mem_cmd_addr}, {2'b11, a});
                check(^mem_cmd_wdata == 1'b0, req, "write-back parity", ^mem_cmd_wdata, 0);
                shadow[a] = merge_exp(shadow[a], d, be);
            end
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                           input logic exp_err, input string req);
        int n;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        check(mem_cmd_valid && !mem_cmd_write && mem_cmd_addr == a, "R2", "read cmd",
              {mem_cmd_valid, mem_cmd_write, mem_cmd_addr}, {2'b10, a});
        n = 1;
        while (!host_rvalid && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == MEM_LAT + 2, "R2", "read latency", n, MEM_LAT + 2);
        check(host_rerr == exp_err, req, "read error flag", host_rerr, exp_err);
        if (!exp_err) check(host_rdata == exp_d, req, "read data", host_rdata, exp_d);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int wr0;
        // R13: reset state
        repeat (3) @(negedge clk);
        check(host_ready && !mem_cmd_valid && !host_rvalid, "R13", "reset handshake",
              {host_ready, mem_cmd_valid, host_rvalid}, 3'b100);
        check(sbe_count == 0 && dbe_count == 0 && irq_status == 0 && !irq, "R13", "reset log",
              {sbe_count, dbe_count, irq_status, irq}, 0);
        rst_n = 1'b1;

        // Table walk: full writes then partial writes (R1, R4), then read back.
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i][AW+DW+BY-1 -: AW], VECS[i][DW+BY-1 -: DW], VECS[i][BY-1:0],
                     1'b0, (&VECS[i][BY-1:0]) ? "R1" : "R4");
        end
        for (int a = 1; a <= 4; a++) do_read(AW'(a), shadow[a], 1'b0, "R4");
        check(sbe_count == 0 && dbe_count == 0, "R1", "no errors on clean words",
              {sbe_count, dbe_count}, 0);

        // R5: single-bit error during read-modify-write
        @(negedge clk); mem[1][10] = ~mem[1][10];
        do_write(4'd1, 64'hDEAD_BEEF_CAFE_F00D, 8'h01, 1'b0, "R5");
        check(sbe_count == 1 && dbe_count == 0, "R5", "sbe counted", {sbe_count, dbe_count}, 6'o10);
        do_read(4'd1, shadow[1], 1'b0, "R5");
        check(sbe_count == 1, "R5", "write-back stored clean word", sbe_count, 1);

        // R7: single-bit error on host read
        @(negedge clk); mem[2][40] = ~mem[2][40];
        do_read(4'd2, shadow[2], 1'b0, "R7");
        check(sbe_count == 2 && !irq, "R7", "sbe counted no irq", {sbe_count, irq}, 4'b0100);

        // R12: host read outstanding when a partial write arrives
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = 4'd4;
        @(negedge clk);
        host_write = 1'b1; host_addr = 4'd2; host_wdata = 64'h0BAD_0000_0000_1234; host_be = 8'h03;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
        begin
            int n;
            n = 0;
            while (!host_rvalid && n < 100) begin
                @(negedge clk);
                n++;
            end
        end
        check(host_rdata == shadow[4] && !host_rerr, "R12", "earlier read delivered",
              host_rdata, shadow[4]);
        shadow[2] = merge_exp(shadow[2], 64'h0BAD_0000_0000_1234, 8'h03);
        do_read(4'd2, shadow[2], 1'b0, "R12");
        check(sbe_count == 3, "R12", "rmw corrected own word", sbe_count, 3);

        // R8: double-bit error on host read
        @(negedge clk); mem[3][5] = ~mem[3][5]; mem[3][9] = ~mem[3][9];
        do_read(4'd3, '0, 1'b1, "R8");
        check(dbe_count == 1 && irq_status == 2'b01, "R8", "dbe counted, read status",
              {dbe_count, irq_status}, 5'b00101);
        check(irq == 1'b1, "R11", "irq on status", irq, 1);

        // R6: double-bit error during read-modify-write aborts write-back
        wr0 = wr_cnt;
        do_write(4'd3, 64'h7777_7777_7777_7777, 8'hF0, 1'b1, "R6");
        @(negedge clk);
        check(wr_cnt == wr0, "R6", "no memory write", wr_cnt, wr0);
        check(dbe_count == 2 && irq_status == 2'b11, "R6", "dbe counted, abort status",
              {dbe_count, irq_status}, 5'b01011);
        do_read(4'd3, '0, 1'b1, "R6");

        // R9: saturation (dbe now 3, six more events exceed the maximum of 7)
        for (int k = 0; k < 6; k++) do_read(4'd3, '0, 1'b1, "R8");
        check(dbe_count == 3'd7, "R9", "dbe saturates", dbe_count, 7);
        check(irq == 1'b1, "R11", "irq holds until clear", irq, 1);

        // R10: clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check(sbe_count == 0 && dbe_count == 0 && irq_status == 0, "R10", "cleared",
              {sbe_count, dbe_count, irq_status}, 0);
        check(irq == 1'b0, "R11", "irq low after clear", irq, 0);

        // Restore address 3 with a full write, confirm clean read.
        do_write(4'd3, 64'h0F0F_F0F0_1234_5678, 8'hFF, 1'b0, "R1");
        do_read(4'd3, shadow[3], 1'b0, "R1");

        summary();
        $finish;
    end

endmodule